// File: doc/BRIEF.md
# Outgoing Message Framer with Indirect Split

This block holds a ring of outgoing messages and turns the oldest one into a stream of 16-bit words toward a host whenever the host asks for a transfer. Each request carries a byte allowance. If the whole message fits, the framer sends a four-word header followed by the message's data words in one phase, then retires the entry. If it does not fit, the framer sends the header with the indirect flag set, followed by a single descriptor word. It then keeps an indirect-pending state. On the next request it sends the data words alone, with no header, capped by that request's allowance, and retires the entry.

Producers load a whole message in one cycle through a separate push port: function code, device code, secondary line number, word count and up to `MAXW` data words. The queue exposes a full flag, and a push while full is dropped. Words leave through a valid/ready handshake. A one-cycle done pulse marks the end of each phase, both the header phase and the data phase.

Top module: `msg_out_framer`

## Requirements
- R1: The ring has `DEPTH` slots and holds at most `DEPTH`-1 messages. `queue_full` is high when advancing the write index by one (mod `DEPTH`) would land on the read index. A push while `queue_full` is high stores nothing.
- R2: A message pushed with n data words (1 ≤ n ≤ `MAXW`) has a header byte count of 10 and a data byte count of (n−1)×2. If it is sent directly, the framer emits, in order: count word = 10+(n−1)×2, function code, device code, a zero spare word, and then data words 0 to n−1.
- R3: Bit 15 of the function code (value 0x8000) is the indirect flag. The message size is 10 if the flag is already set, and 10 plus the data byte count if it is not. If the flag is set, or the size is strictly greater than `xfer_allow`, the message goes indirect. The count word is then `xfer_allow` if the size exceeded it, and the size otherwise. A size equal to the allowance is sent directly.
- R4: In an indirect header phase, the framer emits the count word, the function code with bit 15 forced to 1, the device code and a zero spare word. It then emits one descriptor word: the data byte count in bits 7:0 and the secondary line number in bits 15:8. After this phase `ind_pending` is 1 and the entry stays queued.
- R5: A request that arrives while `ind_pending` is 1 emits only data words, starting from data word 0. The number of words is ceil(min(data byte count, `xfer_allow`)/2), which may be zero. The entry is then retired and `ind_pending` returns to 0.
- R6: The entry is retired after a direct phase and after a data phase, and never after an indirect header phase. Messages leave in push order.
- R7: A request while the queue is empty produces no word and no done pulse.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R9: Each phase ends with exactly one `out_done` pulse. The pulse comes the cycle after the last word is accepted, or the cycle after the request when the phase has zero words.
- R10: After reset, `out_valid`, `out_done`, `queue_full` and `ind_pending` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push one message this cycle |
| push_func | input | 16 | Function code; bit 15 = indirect flag |
| push_dev | input | 16 | Device code |
| push_sdev | input | 8 | Secondary line number for the descriptor |
| push_nwords | input | NW_W | Number of data words, 1..MAXW |
| push_data | input | MAXW*16 | Data words, word k in bits 16k+15:16k |
| queue_full | output | 1 | Ring cannot take another message |
| xfer_req | input | 1 | Transfer request from host, one cycle |
| xfer_allow | input | AL_W | Bytes the host accepts in this transfer |
| out_valid | output | 1 | out_word holds a word |
| out_ready | input | 1 | Host accepts out_word |
| out_word | output | 16 | Outgoing word |
| out_done | output | 1 | One-cycle end-of-phase pulse |
| ind_pending | output | 1 | Head message awaits its data phase |

## Verification
The hardest states to reach from the ports are the two-phase ones. One is a message that is split, then has a data phase cut by a smaller second allowance. The other is a split message whose data phase carries zero words, so the done pulse and the retirement happen with nothing on the output. The stimulus reaches these in three ways: it pushes eight-word messages with allowances below the message size; it chooses a second allowance that is odd and smaller than the data byte count; and it pushes a one-word message with the flag already set. A further run fills the ring to its last free slot, pushes once more into the full ring, and then drains it with a throttled ready. This checks push order and confirms that the dropped message never appears.

// File: rtl/mof_pkg.sv
package mof_pkg;
    localparam int WORD_W    = 16;
    localparam int HDR_WORDS = 4;
    localparam int HDR_BYTES = 10;
    localparam int IND_BIT   = 15;
    localparam logic [WORD_W-1:0] IND_FLAG = 16'h8000;

    typedef logic [WORD_W-1:0] word_t;

    // Header fields kept per ring slot
    typedef struct packed {
        word_t      func;
        word_t      dev;
        logic [7:0] sdev;
        logic [7:0] dbytes;
    } msg_hdr_t;

    typedef enum logic [1:0] {
        PH_DIRECT    = 2'd0,
        PH_SPLIT_HDR = 2'd1,
        PH_DATA      = 2'd2
    } phase_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } state_e;

    // Data byte count recorded for a message of nw words
    function automatic logic [7:0] data_bytes(input logic [7:0] nw);
        return (nw - 8'd1) << 1;
    endfunction

    // Width of a per-phase word counter
    function automatic int emit_cnt_w(input int maxw);
        return $clog2(maxw + HDR_WORDS + 2);
    endfunction
endpackage

// File: rtl/mof_ring.sv
module mof_ring
    import mof_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int MAXW  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int DW    = MAXW * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  msg_hdr_t         push_hdr,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic             full,
    output logic             empty,
    output msg_hdr_t         head_hdr,
    output logic [DW-1:0]    head_data,
    output logic [PTR_W-1:0] head_ptr
);
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    msg_hdr_t         hdr_mem  [DEPTH];
    logic [DW-1:0]    data_mem [DEPTH];
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (bump(wr_ptr) == rd_ptr);
    assign empty    = (wr_ptr == rd_ptr);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head_hdr = hdr_mem[rd_ptr];
    assign head_data = data_mem[rd_ptr];
    assign head_ptr = rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            hdr_mem[wr_ptr]  <= push_hdr;
            data_mem[wr_ptr] <= push_data;
        end
    end
endmodule

// File: rtl/mof_sizer.sv
module mof_sizer
    import mof_pkg::*;
#(
    parameter int MAXW = 8,
    parameter int AL_W = 12,
    localparam int CW  = emit_cnt_w(MAXW)
) (
    input  logic            flagged,
    input  logic [7:0]      dbytes,
    input  logic [AL_W-1:0] allow,
    input  logic            pending,
    output phase_e          phase,
    output logic [CW-1:0]   n_emit,
    output word_t           count_field
);
    typedef logic [AL_W-1:0] al_t;

    al_t  db_w, total, part;
    logic over;

    always_comb begin
        db_w  = al_t'(dbytes);
        total = flagged ? al_t'(HDR_BYTES) : al_t'(HDR_BYTES) + db_w;
        over  = (total > allow);
        part  = (db_w > allow) ? allow : db_w;
        count_field = word_t'(total);
        if (pending) begin
            // second phase: data only, bytes capped by this allowance
            phase  = PH_DATA;
            n_emit = CW'((part + 1'b1) >> 1);
        end else if (flagged || over) begin
            phase  = PH_SPLIT_HDR;
            n_emit = CW'(HDR_WORDS + 1);
            if (over) count_field = word_t'(allow);
        end else begin
            phase  = PH_DIRECT;
            n_emit = CW'(HDR_WORDS + 1 + int'(dbytes >> 1));
        end
    end
endmodule

// File: rtl/mof_emitter.sv
module mof_emitter
    import mof_pkg::*;
#(
    parameter int MAXW = 8,
    localparam int CW  = emit_cnt_w(MAXW),
    localparam int DW  = MAXW * WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_req,
    input  logic          empty,
    input  msg_hdr_t      head,
    input  logic [DW-1:0] head_data,
    input  phase_e        sz_phase,
    input  logic [CW-1:0] sz_n,
    input  word_t         sz_count,
    input  logic          out_ready,
    output logic          out_valid,
    output word_t         out_word,
    output logic          out_done,
    output logic          pop,
    output logic          pending
);
    word_t         lane [MAXW];
    state_e        state;
    phase_e        phase_q, fin_phase;
    logic [CW-1:0] idx, n_q, dsel;
    word_t         count_q, data_w;
    logic          start, accept, last, finish, split;

    for (genvar g = 0; g < MAXW; g++) begin : g_lane
        assign lane[g] = head_data[g*WORD_W +: WORD_W];
    end

    always_comb begin
        start     = (state == ST_IDLE) && xfer_req && !empty;
        accept    = (state == ST_SEND) && out_ready;
        last      = (idx == n_q - 1'b1);
        finish    = (start && (sz_n == '0)) || (accept && last);
        fin_phase = (state == ST_IDLE) ? sz_phase : phase_q;
        pop       = finish && (fin_phase != PH_SPLIT_HDR);
        out_valid = (state == ST_SEND);
        split     = (phase_q == PH_SPLIT_HDR);
    end

    // word selection for the current index
    always_comb begin
        dsel   = (phase_q == PH_DATA) ? idx : idx - CW'(HDR_WORDS);
        data_w = '0;
        for (int w = 0; w < MAXW; w++) begin
            if (dsel == CW'(w)) data_w = lane[w];
        end
        out_word = data_w;
        if (phase_q != PH_DATA) begin
            case (idx)
                CW'(0):  out_word = count_q;
                CW'(1):  out_word = head.func | (split ? IND_FLAG : '0);
                CW'(2):  out_word = head.dev;
                CW'(3):  out_word = '0;
                default: if (split) out_word = {head.sdev, head.dbytes};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase_q  <= PH_DIRECT;
            idx      <= '0;
            n_q      <= '0;
            count_q  <= '0;
            pending  <= 1'b0;
            out_done <= 1'b0;
        end else begin
            out_done <= finish;
            if (finish) pending <= (fin_phase == PH_SPLIT_HDR);
            case (state)
                ST_IDLE: begin
                    if (start && (sz_n != '0)) begin
                        state   <= ST_SEND;
                        phase_q <= sz_phase;
                        n_q     <= sz_n;
                        count_q <= sz_count;
                        idx     <= '0;
                    end
                end
                ST_SEND: begin
                    if (accept) begin
                        if (last) state <= ST_IDLE;
                        else      idx   <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msg_out_framer.sv
module msg_out_framer
    import mof_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int MAXW  = 8,
    parameter int AL_W  = 12,
    localparam int NW_W = $clog2(MAXW + 1),
    localparam int DW   = MAXW * WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_valid,
    input  logic [15:0]     push_func,
    input  logic [15:0]     push_dev,
    input  logic [7:0]      push_sdev,
    input  logic [NW_W-1:0] push_nwords,
    input  logic [DW-1:0]   push_data,
    output logic            queue_full,
    input  logic            xfer_req,
    input  logic [AL_W-1:0] xfer_allow,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [15:0]     out_word,
    output logic            out_done,
    output logic            ind_pending
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CW    = emit_cnt_w(MAXW);

    msg_hdr_t         push_hdr, head_hdr;
    logic [DW-1:0]    head_data;
    logic [PTR_W-1:0] head_ptr;
    logic             ring_empty, ring_pop;
    phase_e           sz_phase;
    logic [CW-1:0]    sz_n;
    word_t            sz_count;

    always_comb begin
        push_hdr.func   = push_func;
        push_hdr.dev    = push_dev;
        push_hdr.sdev   = push_sdev;
        push_hdr.dbytes = data_bytes(8'(push_nwords));
    end

    mof_ring #(.DEPTH(DEPTH), .MAXW(MAXW)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (push_valid),
        .push_hdr  (push_hdr),
        .push_data (push_data),
        .pop       (ring_pop),
        .full      (queue_full),
        .empty     (ring_empty),
        .head_hdr  (head_hdr),
        .head_data (head_data),
        .head_ptr  (head_ptr)
    );

    mof_sizer #(.MAXW(MAXW), .AL_W(AL_W)) u_sizer (
        .flagged     (head_hdr.func[IND_BIT]),
        .dbytes      (head_hdr.dbytes),
        .allow       (xfer_allow),
        .pending     (ind_pending),
        .phase       (sz_phase),
        .n_emit      (sz_n),
        .count_field (sz_count)
    );

    mof_emitter #(.MAXW(MAXW)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .xfer_req  (xfer_req),
        .empty     (ring_empty),
        .head      (head_hdr),
        .head_data (head_data),
        .sz_phase  (sz_phase),
        .sz_n      (sz_n),
        .sz_count  (sz_count),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_done  (out_done),
        .pop       (ring_pop),
        .pending   (ind_pending)
    );
endmodule

// File: rtl/mof_chk.sv
module mof_chk #(
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic             out_ready,
    input logic [15:0]      out_word,
    input logic             out_done,
    input logic             ind_pending,
    input logic             queue_full,
    input logic             xfer_req,
    input logic             ring_empty,
    input logic [PTR_W-1:0] head_ptr
);
    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    // R7
    empty_req_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid && xfer_req && ring_empty |=> !out_valid && !out_done);

    // R4
    pending_held_chk: assert property (@(posedge clk) disable iff (rst)
        ind_pending |-> !ring_empty);

    // R4
    split_keep_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ind_pending) |-> out_done && $stable(head_ptr));

    // R6
    retire_done_chk: assert property (@(posedge clk) disable iff (rst)
        head_ptr != $past(head_ptr) |-> out_done);

    // R1
    full_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        queue_full |-> !ring_empty);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        out_done |-> !out_valid);
endmodule

bind msg_out_framer mof_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_word    (out_word),
    .out_done    (out_done),
    .ind_pending (ind_pending),
    .queue_full  (queue_full),
    .xfer_req    (xfer_req),
    .ring_empty  (ring_empty),
    .head_ptr    (head_ptr)
);

// File: tb/msg_out_framer_tb.sv
module msg_out_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int MAXW  = 8;
    localparam int AL_W  = 12;
    localparam int NW_W  = $clog2(MAXW + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push_valid = 1'b0;
    logic [15:0] push_func = '0, push_dev = '0;
    logic [7:0]  push_sdev = '0;
    logic [NW_W-1:0] push_nwords = '0;
    logic [MAXW*16-1:0] push_data = '0;
    logic queue_full;
    logic xfer_req = 1'b0;
    logic [AL_W-1:0] xfer_allow = '0;
    logic out_valid, out_done, ind_pending;
    logic out_ready = 1'b1;
    logic [15:0] out_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_out_framer #(.DEPTH(DEPTH), .MAXW(MAXW), .AL_W(AL_W)) u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_func(push_func),
        .push_dev(push_dev), .push_sdev(push_sdev), .push_nwords(push_nwords),
        .push_data(push_data), .queue_full(queue_full), .xfer_req(xfer_req),
        .xfer_allow(xfer_allow), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_done(out_done), .ind_pending(ind_pending)
    );

    int total = 0, bad = 0, cyc = 0;
    int cap_n = 0, done_n = 0;
    logic [15:0] cap [64];
    bit stall_en = 1'b0;
    bit ended = 1'b0;

    // model of queued messages, linear indices
    logic [15:0] m_func [64];
    logic [15:0] m_dev  [64];
    logic [7:0]  m_sdev [64];
    int          m_n    [64];
    logic [15:0] m_data [64][MAXW];
    int mh = 0, mt = 0;
    bit mpend = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (out_valid && out_ready) begin
            if (cap_n < 64) cap[cap_n] = out_word;
            cap_n++;
        end
        if (out_done) done_n++;
    end

    always @(negedge clk) out_ready = !stall_en || (cyc % 3 != 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic push_msg(input logic [15:0] func, input logic [15:0] dev,
                            input logic [7:0] sdev, input int n, input bit store);
        @(negedge clk);
        push_func   = func;
        push_dev    = dev;
        push_sdev   = sdev;
        push_nwords = NW_W'(n);
        for (int w = 0; w < MAXW; w++) begin
            logic [15:0] v;
            v = {dev[7:0] ^ 8'h5A, 8'(w * 17 + 1)};
            push_data[w*16 +: 16] = (w < n) ? v : 16'h0;
            if (store) m_data[mt][w] = v;
        end
        if (store) begin
            m_func[mt] = func; m_dev[mt] = dev; m_sdev[mt] = sdev; m_n[mt] = n;
            mt++;
        end
        push_valid = 1'b1;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // one transfer request, expected words derived from the requirements
    task automatic run_xfer(input int allow, input string req);
        logic [15:0] exp [16];
        int exp_n = 0;
        bit exp_done = 1'b0;
        int k = 0;
        if (mh != mt) begin
            int db;
            db = (m_n[mh] - 1) * 2;
            exp_done = 1'b1;
            if (mpend) begin
                int b;
                b = (db < allow) ? db : allow;
                exp_n = (b + 1) / 2;
                for (int i = 0; i < exp_n; i++) exp[i] = m_data[mh][i];
                mpend = 1'b0;
                mh++;
            end else begin
                int sz;
                bit fl;
                fl = m_func[mh][15];
                sz = fl ? 10 : 10 + db;
                exp[0] = 16'(sz);
                exp[1] = m_func[mh];
                exp[2] = m_dev[mh];
                exp[3] = 16'h0;
                if (fl || sz > allow) begin
                    if (sz > allow) exp[0] = 16'(allow);
                    exp[1] = m_func[mh] | 16'h8000;
                    exp[4] = {m_sdev[mh], 8'(db)};
                    exp_n = 5;
                    mpend = 1'b1;
                end else begin
                    for (int i = 0; i < m_n[mh]; i++) exp[4+i] = m_data[mh][i];
                    exp_n = 4 + m_n[mh];
                    mh++;
                end
            end
        end
        cap_n = 0;
        done_n = 0;
        @(negedge clk);
        xfer_req = 1'b1;
        xfer_allow = AL_W'(allow);
        @(negedge clk);
        xfer_req = 1'b0;
        while (done_n == 0 && k < 80) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        chk(cap_n == exp_n, {req, " word count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            chk(cap[i] == exp[i], {req, " word"}, cap[i], exp[i]);
        chk(done_n == int'(exp_done), {req, " done pulses (R9)"}, done_n, int'(exp_done));
        chk(ind_pending == mpend, {req, " pending state"}, ind_pending, mpend);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
        chk(out_done == 1'b0, "R10 out_done", out_done, 0);
        chk(queue_full == 1'b0, "R10 queue_full", queue_full, 0);
        chk(ind_pending == 1'b0, "R10 ind_pending", ind_pending, 0);
    endtask

    task automatic t_empty();
        run_xfer(100, "R7 empty request");
    endtask

    task automatic t_direct();
        push_msg(16'h0003, 16'h000A, 8'h00, 3, 1'b1);
        run_xfer(100, "R2 direct");
        run_xfer(100, "R6 retired after direct");
    endtask

    task automatic t_stall();
        stall_en = 1'b1;
        push_msg(16'h0021, 16'h0031, 8'h02, 5, 1'b1);
        run_xfer(100, "R8 throttled direct");
        stall_en = 1'b0;
    endtask

    task automatic t_split();
        push_msg(16'h0005, 16'h0042, 8'h07, 6, 1'b1);
        run_xfer(12, "R4 split header");
        run_xfer(100, "R5 data phase");
    endtask

    task automatic t_capped();
        push_msg(16'h0011, 16'h0055, 8'h3C, 8, 1'b1);
        run_xfer(8, "R3 over allowance");
        run_xfer(5, "R5 capped data phase");
    endtask

    task automatic t_preflag();
        push_msg(16'h8011, 16'h0066, 8'h09, 2, 1'b1);
        run_xfer(100, "R3 preflagged");
        run_xfer(100, "R5 preflagged data");
    endtask

    task automatic t_boundary();
        push_msg(16'h0007, 16'h0071, 8'h01, 4, 1'b1);
        push_msg(16'h0008, 16'h0072, 8'h02, 4, 1'b1);
        run_xfer(16, "R3 equal fits");
        run_xfer(15, "R3 one over");
        run_xfer(15, "R5 after one over");
    endtask

    task automatic t_zero();
        push_msg(16'h8002, 16'h0080, 8'hA5, 1, 1'b1);
        run_xfer(50, "R4 zero data header");
        run_xfer(50, "R5 zero data phase");
        run_xfer(50, "R6 retired after zero phase");
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH - 1; i++)
            push_msg(16'h0100 + 16'(i), 16'h0200 + 16'(i), 8'(i), 1 + (i % MAXW), 1'b1);
        chk(queue_full == 1'b1, "R1 full at DEPTH-1", queue_full, 1);
        push_msg(16'h0BAD, 16'h0BAD, 8'hFF, 2, 1'b0);
        chk(queue_full == 1'b1, "R1 still full", queue_full, 1);
        stall_en = 1'b1;
        for (int i = 0; i < DEPTH - 1; i++) run_xfer(200, "R6 push order");
        stall_en = 1'b0;
        run_xfer(200, "R1 rejected push absent");
        chk(queue_full == 1'b0, "R1 not full after drain", queue_full, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty();
        t_direct();
        t_stall();
        t_split();
        t_capped();
        t_preflag();
        t_boundary();
        t_zero();
        t_full();
        summary();
    end
endmodule